// File: doc/BRIEF.md
# Switch configuration write handler

This block sits on the configuration port of a network switch. It reads a stream of symbols, one per cycle. Each symbol carries a flag that says whether it is a control token or a data byte. From that stream it picks out configuration write requests. A request first names a target register bank and gives a destination node byte. It then carries a write command, the requester's three-byte return identifier, a 16-bit register address and a 32-bit word. A closing token ends the request.

When a request is well formed, the block commits the word into one of two small register banks, the system bank or the processor bank. It then emits an acknowledge reply on an output symbol stream. The reply is led by the captured return identifier, which the fabric uses to route it. Register 0 of the system bank holds the switch's own node identifier. A request can rewrite that identifier whatever node byte it carries in its header.

A malformed request leaves no trace. This covers a misplaced token, a missing closing token and an address outside the bank. The register file, including the node identifier, is also readable by the surrounding switch logic through a combinational read port.

Top module: `cfg_write_handler`

## Requirements
- R1: After synchronous reset, `out_valid` is 0, every register in both banks reads 0 and `node_id` is 0.
- R2: A request is: a target control token, then one destination data byte, then the write control token 0xC0, then three return-identifier data bytes (node, processor, channel), then two address data bytes (bits 15..8 first), then four data bytes (bits 31..24 first), then the end control token 0x01. Such a request stores the 32-bit word at the given address.
- R3: Target token 0xC2 selects the system bank and 0xC3 selects the processor bank. A write to one bank leaves the other unchanged.
- R4: A committed write produces exactly five output symbols on consecutive cycles, starting the cycle after the end token is taken. The first three are the data bytes node, processor and channel. Then comes control 0x03, then control 0x01. `out_ctrl` is 1 only on the last two.
- R5: The destination node byte is never compared with `node_id`. A write to system address 0 updates `node_id` (bits 7..0 of the word) in the same cycle as the commit, visible right after the end token's clock edge.
- R6: A control token in any data-byte position (destination, return identifier, address or data), or anything other than 0xC0 in the command position, drops the request: no write, no reply, and the parser returns to idle.
- R7: If the symbol after the fourth data byte is not the control token 0x01, the request is dropped with no write and no reply.
- R8: An address of NREGS or above (including any nonzero high byte) is dropped with no write and no reply.
- R9: While idle, any symbol other than control 0xC2/0xC3 is ignored. Every input symbol that arrives while a reply is being sent is ignored.
- R10: No register changes before the end token is taken. A request that has delivered all four data bytes but no end token leaves the target register at its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input symbol present this cycle |
| in_ctrl | input | 1 | Input symbol is a control token |
| in_data | input | 8 | Input symbol value |
| out_valid | output | 1 | Reply symbol present this cycle |
| out_ctrl | output | 1 | Reply symbol is a control token |
| out_data | output | 8 | Reply symbol value |
| rd_bank | input | 1 | Read port bank select (0 system, 1 processor) |
| rd_idx | input | $clog2(NREGS) | Read port register index |
| rd_data | output | 32 | Register contents at the read index |
| node_id | output | 8 | Current switch node identifier |

## Verification
Clean requests are sent to both banks with distinct return identifiers, data words and addresses. This separates bank selection, byte ordering and reply routing. A node-identifier write uses a header node byte that differs from the current identifier, so it shows that no match is required.

Faulty frames then test the parser's error paths. One has a token in the address field. Others have a data byte or a wrong token where the end token belongs. Others have out-of-range addresses whose low bits alias a live register. Each one must leave the registers and reply stream untouched.

Noise is sent while idle, and a complete header is injected during a reply. These show that neither can start or disturb a request.

// File: rtl/cfg_write_pkg.sv
package cfg_write_pkg;

    localparam logic [7:0] TOK_WRITE    = 8'hC0;
    localparam logic [7:0] TOK_END      = 8'h01;
    localparam logic [7:0] TOK_ACK      = 8'h03;
    localparam logic [7:0] TOK_SYS_SEL  = 8'hC2;
    localparam logic [7:0] TOK_PROC_SEL = 8'hC3;

    localparam int ADDR_W   = 16;
    localparam int WORD_W   = 32;
    localparam int REPLY_LEN = 5;

    typedef enum logic [3:0] {
        PS_IDLE,
        PS_DEST,
        PS_CMD,
        PS_RET,
        PS_ADDR,
        PS_DATA,
        PS_TERM,
        PS_REPLY
    } parse_state_e;

    typedef struct packed {
        logic [7:0] node;
        logic [7:0] proc;
        logic [7:0] chan;
    } ret_id_t;

    typedef struct packed {
        logic       ctrl;
        logic [7:0] data;
    } symbol_t;

    function automatic logic is_target_tok(input logic ctrl, input logic [7:0] d);
        return ctrl && (d == TOK_SYS_SEL || d == TOK_PROC_SEL);
    endfunction

endpackage

// File: rtl/cfg_parser.sv
module cfg_parser
    import cfg_write_pkg::*;
#(
    parameter int NREGS = 8,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_ctrl,
    input  logic [7:0]         in_data,
    output logic               wr_en,
    output logic               wr_bank,
    output logic [IDX_W-1:0]   wr_idx,
    output logic [WORD_W-1:0]  wr_word,
    output logic               reply_on,
    output logic [2:0]         reply_step,
    output ret_id_t            ret_id
);

    parse_state_e        state_q;
    logic [2:0]          cnt_q;
    logic                bank_q;
    ret_id_t             ret_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [WORD_W-1:0]   word_q;
    logic                addr_ok;
    logic                end_seen;

    assign addr_ok  = (addr_q < ADDR_W'(NREGS));
    assign end_seen = in_valid && in_ctrl && (in_data == TOK_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_IDLE;
            cnt_q   <= '0;
            bank_q  <= 1'b0;
            ret_q   <= '0;
            addr_q  <= '0;
            word_q  <= '0;
        end else begin
            unique case (state_q)
                PS_IDLE: begin
                    if (in_valid && is_target_tok(in_ctrl, in_data)) begin
                        bank_q  <= (in_data == TOK_PROC_SEL);
                        state_q <= PS_DEST;
                    end
                end
                PS_DEST: begin
                    if (in_valid) state_q <= in_ctrl ? PS_IDLE : PS_CMD;
                end
                PS_CMD: begin
                    if (in_valid) begin
                        cnt_q   <= '0;
                        state_q <= (in_ctrl && in_data == TOK_WRITE) ? PS_RET : PS_IDLE;
                    end
                end
                PS_RET: begin
                    if (in_valid) begin
                        if (in_ctrl) begin
                            state_q <= PS_IDLE;
                        end else begin
                            ret_q <= {ret_q.proc, ret_q.chan, in_data};
                            cnt_q <= cnt_q + 3'd1;
                            if (cnt_q == 3'd2) begin
                                cnt_q   <= '0;
                                state_q <= PS_ADDR;
                            end
                        end
                    end
                end
                PS_ADDR: begin
                    if (in_valid) begin
                        if (in_ctrl) begin
                            state_q <= PS_IDLE;
                        end else begin
                            addr_q <= {addr_q[7:0], in_data};
                            cnt_q  <= cnt_q + 3'd1;
                            if (cnt_q == 3'd1) begin
                                cnt_q   <= '0;
                                state_q <= PS_DATA;
                            end
                        end
                    end
                end
                PS_DATA: begin
                    if (in_valid) begin
                        if (in_ctrl) begin
                            state_q <= PS_IDLE;
                        end else begin
                            word_q <= {word_q[WORD_W-9:0], in_data};
                            cnt_q  <= cnt_q + 3'd1;
                            if (cnt_q == 3'd3) begin
                                cnt_q   <= '0;
                                state_q <= PS_TERM;
                            end
                        end
                    end
                end
                PS_TERM: begin
                    if (in_valid) begin
                        cnt_q   <= '0;
                        state_q <= (end_seen && addr_ok) ? PS_REPLY : PS_IDLE;
                    end
                end
                PS_REPLY: begin
                    cnt_q <= cnt_q + 3'd1;
                    if (cnt_q == 3'(REPLY_LEN - 1)) begin
                        cnt_q   <= '0;
                        state_q <= PS_IDLE;
                    end
                end
                default: state_q <= PS_IDLE;
            endcase
        end
    end

    assign wr_en      = (state_q == PS_TERM) && end_seen && addr_ok;
    assign wr_bank    = bank_q;
    assign wr_idx     = addr_q[IDX_W-1:0];
    assign wr_word    = word_q;
    assign reply_on   = (state_q == PS_REPLY);
    assign reply_step = cnt_q;
    assign ret_id     = ret_q;

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfg_write_pkg::*;
#(
    parameter int NREGS = 8,
    localparam int IDX_W = $clog2(NREGS),
    localparam int NBANKS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_bank,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data,
    output logic [7:0]        node_id
);

    logic [WORD_W-1:0] bank_rd [NBANKS];
    logic [WORD_W-1:0] bank_r0 [NBANKS];

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        logic [WORD_W-1:0] regs_q [NREGS];
        logic              sel;

        assign sel = wr_en && (wr_bank == 1'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
            end else if (sel) begin
                regs_q[wr_idx] <= wr_word;
            end
        end

        assign bank_rd[b] = regs_q[rd_idx];
        assign bank_r0[b] = regs_q[0];
    end

    assign rd_data = bank_rd[rd_bank];
    assign node_id = bank_r0[0][7:0];

endmodule

// File: rtl/cfg_reply.sv
module cfg_reply
    import cfg_write_pkg::*;
(
    input  logic       reply_on,
    input  logic [2:0] reply_step,
    input  ret_id_t    ret_id,
    output logic       out_valid,
    output logic       out_ctrl,
    output logic [7:0] out_data
);

    symbol_t sym;

    always_comb begin
        unique case (reply_step)
            3'd0:    sym = '{ctrl: 1'b0, data: ret_id.node};
            3'd1:    sym = '{ctrl: 1'b0, data: ret_id.proc};
            3'd2:    sym = '{ctrl: 1'b0, data: ret_id.chan};
            3'd3:    sym = '{ctrl: 1'b1, data: TOK_ACK};
            3'd4:    sym = '{ctrl: 1'b1, data: TOK_END};
            default: sym = '{ctrl: 1'b0, data: 8'h00};
        endcase
    end

    assign out_valid = reply_on;
    assign out_ctrl  = reply_on && sym.ctrl;
    assign out_data  = reply_on ? sym.data : 8'h00;

endmodule

// File: rtl/cfg_write_handler.sv
module cfg_write_handler
    import cfg_write_pkg::*;
#(
    parameter int NREGS = 8,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_ctrl,
    input  logic [7:0]        in_data,
    output logic              out_valid,
    output logic              out_ctrl,
    output logic [7:0]        out_data,
    input  logic              rd_bank,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data,
    output logic [7:0]        node_id
);

    logic              wr_en;
    logic              wr_bank;
    logic [IDX_W-1:0]  wr_idx;
    logic [WORD_W-1:0] wr_word;
    logic              reply_on;
    logic [2:0]        reply_step;
    ret_id_t           ret_id;

    cfg_parser #(.NREGS(NREGS)) u_parser (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ctrl    (in_ctrl),
        .in_data    (in_data),
        .wr_en      (wr_en),
        .wr_bank    (wr_bank),
        .wr_idx     (wr_idx),
        .wr_word    (wr_word),
        .reply_on   (reply_on),
        .reply_step (reply_step),
        .ret_id     (ret_id)
    );

    cfg_regfile #(.NREGS(NREGS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_bank (wr_bank),
        .wr_idx  (wr_idx),
        .wr_word (wr_word),
        .rd_bank (rd_bank),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .node_id (node_id)
    );

    cfg_reply u_reply (
        .reply_on   (reply_on),
        .reply_step (reply_step),
        .ret_id     (ret_id),
        .out_valid  (out_valid),
        .out_ctrl   (out_ctrl),
        .out_data   (out_data)
    );

endmodule

// File: rtl/cfg_write_handler_checker.sv
module cfg_write_handler_checker (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_ctrl,
    input logic [7:0] in_data,
    input logic       out_valid,
    input logic       out_ctrl,
    input logic [7:0] out_data,
    input logic [7:0] node_id,
    input logic       wr_en
);

    a_r4_ack_then_end: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ctrl && out_data == 8'h03) |=> (out_valid && out_ctrl && out_data == 8'h01));

    a_r4_reply_starts_with_data: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> !out_ctrl);

    a_r4_reply_follows_end: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_valid && in_ctrl && in_data == 8'h01));

    a_r10_commit_on_end: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (in_valid && in_ctrl && in_data == 8'h01));

    a_r5_node_id_only_on_commit: assert property (@(posedge clk) disable iff (rst)
        !$stable(node_id) |-> $past(wr_en));

    a_r4_commit_gives_reply: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (out_valid && !out_ctrl));

endmodule

bind cfg_write_handler cfg_write_handler_checker u_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ctrl   (in_ctrl),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ctrl  (out_ctrl),
    .out_data  (out_data),
    .node_id   (node_id),
    .wr_en     (wr_en)
);

// File: tb/cfg_write_handler_tb.sv
`timescale 1ns/1ps
module cfg_write_handler_tb;

    localparam int NREGS = 8;
    localparam int IDX_W = $clog2(NREGS);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic             in_ctrl = 1'b0;
    logic [7:0]       in_data = 8'h00;
    logic             out_valid;
    logic             out_ctrl;
    logic [7:0]       out_data;
    logic             rd_bank = 1'b0;
    logic [IDX_W-1:0] rd_idx = '0;
    logic [31:0]      rd_data;
    logic [7:0]       node_id;

    int checks = 0;
    int errors = 0;
    logic [8:0] exp_q[$];

    always #10 clk = ~clk;

    cfg_write_handler #(.NREGS(NREGS)) u_dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ctrl(in_ctrl), .in_data(in_data),
        .out_valid(out_valid), .out_ctrl(out_ctrl), .out_data(out_data),
        .rd_bank(rd_bank), .rd_idx(rd_idx), .rd_data(rd_data),
        .node_id(node_id)
    );

    // Monitor: pops expected reply symbols (R4), flags any unexpected one.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R4 unexpected reply symbol: got ctrl=%0b data=%02h, expected none",
                         out_ctrl, out_data);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                if ({out_ctrl, out_data} !== e) begin
                    errors++;
                    $display("FAIL R4 reply symbol: got %03h expected %03h", {out_ctrl, out_data}, e);
                end
            end
        end
    end

    task automatic put(input logic c, input logic [7:0] d);
        in_valid = 1'b1;
        in_ctrl  = c;
        in_data  = d;
        @(negedge clk);
        in_valid = 1'b0;
        in_ctrl  = 1'b0;
        in_data  = 8'h00;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_body(input logic [7:0] tgt, input logic [7:0] dest,
                             input logic [23:0] ret, input logic [15:0] addr,
                             input logic [31:0] word);
        put(1'b1, tgt);
        put(1'b0, dest);
        put(1'b1, 8'hC0);
        put(1'b0, ret[23:16]);
        put(1'b0, ret[15:8]);
        put(1'b0, ret[7:0]);
        put(1'b0, addr[15:8]);
        put(1'b0, addr[7:0]);
        put(1'b0, word[31:24]);
        put(1'b0, word[23:16]);
        put(1'b0, word[15:8]);
        put(1'b0, word[7:0]);
    endtask

    task automatic expect_reply(input logic [23:0] ret);
        exp_q.push_back({1'b0, ret[23:16]});
        exp_q.push_back({1'b0, ret[15:8]});
        exp_q.push_back({1'b0, ret[7:0]});
        exp_q.push_back({1'b1, 8'h03});
        exp_q.push_back({1'b1, 8'h01});
    endtask

    // Full good write; returns at the negedge right after the END edge.
    task automatic good_write(input logic [7:0] tgt, input logic [7:0] dest,
                              input logic [23:0] ret, input logic [15:0] addr,
                              input logic [31:0] word);
        expect_reply(ret);
        send_body(tgt, dest, ret, addr, word);
        put(1'b1, 8'h01);
    endtask

    task automatic check_reg(input logic b, input int idx, input logic [31:0] exp, input string req);
        rd_bank = b;
        rd_idx  = IDX_W'(idx);
        #1;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s reg bank%0d[%0d]: got %08h expected %08h", req, b, idx, rd_data, exp);
        end
    endtask

    task automatic check_node(input logic [7:0] exp, input string req);
        checks++;
        if (node_id !== exp) begin
            errors++;
            $display("FAIL %s node_id: got %02h expected %02h", req, node_id, exp);
        end
    endtask

    task automatic check_quiet(input string req);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s pending reply symbols: got %0d expected 0", req, exp_q.size());
        end
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 out_valid: got %0b expected 0", out_valid);
        end
        check_node(8'h00, "R1");
        check_reg(1'b0, 3, 32'h0, "R1");
        check_reg(1'b1, 5, 32'h0, "R1");

        // R2/R3/R4: system bank write, MSB-first fields
        good_write(8'hC2, 8'h00, 24'h05_01_22, 16'h0003, 32'hDEADBEEF);
        idle(6);
        check_reg(1'b0, 3, 32'hDEADBEEF, "R2");
        check_reg(1'b1, 3, 32'h0, "R3");
        check_quiet("R4");

        // R3: processor bank write, other bank untouched
        good_write(8'hC3, 8'h11, 24'h7A_02_0F, 16'h0003, 32'h12345678);
        idle(6);
        check_reg(1'b1, 3, 32'h12345678, "R3");
        check_reg(1'b0, 3, 32'hDEADBEEF, "R3");

        // R5: node id write with mismatching header node byte
        good_write(8'hC2, 8'h3C, 24'h01_00_04, 16'h0000, 32'h000000A7);
        check_node(8'hA7, "R5");
        idle(6);
        check_quiet("R5");

        // R10: all data bytes but no END yet -> unchanged; then END commits
        expect_reply(24'h09_08_07);
        send_body(8'hC2, 8'h00, 24'h09_08_07, 16'h0006, 32'hCAFEF00D);
        idle(2);
        check_reg(1'b0, 6, 32'h0, "R10");
        put(1'b1, 8'h01);
        idle(6);
        check_reg(1'b0, 6, 32'hCAFEF00D, "R10");

        // R6: control token in address position drops the request
        put(1'b1, 8'hC2); put(1'b0, 8'h00); put(1'b1, 8'hC0);
        put(1'b0, 8'h01); put(1'b0, 8'h02); put(1'b0, 8'h03);
        put(1'b0, 8'h00); put(1'b1, 8'h07);
        put(1'b0, 8'h11); put(1'b0, 8'h22); put(1'b0, 8'h33); put(1'b0, 8'h44);
        put(1'b1, 8'h01);
        idle(6);
        check_reg(1'b0, 7, 32'h0, "R6");
        check_quiet("R6");
        // R6: wrong command token
        put(1'b1, 8'hC3); put(1'b0, 8'h00); put(1'b1, 8'hC1);
        put(1'b0, 8'h01); put(1'b0, 8'h02); put(1'b0, 8'h03);
        put(1'b0, 8'h00); put(1'b0, 8'h01);
        put(1'b0, 8'h11); put(1'b0, 8'h22); put(1'b0, 8'h33); put(1'b0, 8'h44);
        put(1'b1, 8'h01);
        idle(6);
        check_reg(1'b1, 1, 32'h0, "R6");

        // R7: data byte where END belongs, then wrong control token
        send_body(8'hC2, 8'h00, 24'h01_01_01, 16'h0002, 32'h55555555);
        put(1'b0, 8'h01);
        idle(6);
        check_reg(1'b0, 2, 32'h0, "R7");
        send_body(8'hC3, 8'h00, 24'h01_01_01, 16'h0002, 32'h66666666);
        put(1'b1, 8'h02);
        idle(6);
        check_reg(1'b1, 2, 32'h0, "R7");
        check_quiet("R7");

        // R8: out-of-range addresses (low bits alias registers 0 and 4)
        send_body(8'hC2, 8'h00, 24'h02_02_02, 16'h0100, 32'h000000FF);
        put(1'b1, 8'h01);
        idle(6);
        check_node(8'hA7, "R8");
        check_reg(1'b0, 0, 32'h000000A7, "R8");
        send_body(8'hC3, 8'h00, 24'h02_02_02, 16'h000C, 32'h77777777);
        put(1'b1, 8'h01);
        idle(6);
        check_reg(1'b1, 4, 32'h0, "R8");
        check_quiet("R8");

        // R9: idle noise ignored, then symbols during reply ignored
        put(1'b0, 8'hC2); put(1'b1, 8'hC0); put(1'b1, 8'h01); put(1'b0, 8'h55);
        idle(2);
        check_quiet("R9");
        expect_reply(24'h0A_0B_0C);
        send_body(8'hC3, 8'h00, 24'h0A_0B_0C, 16'h0005, 32'hA5A5A5A5);
        put(1'b1, 8'h01);
        put(1'b1, 8'hC3); put(1'b0, 8'h00); put(1'b1, 8'hC0);
        put(1'b0, 8'h01); put(1'b0, 8'h02);
        idle(2);
        check_reg(1'b1, 5, 32'hA5A5A5A5, "R9");
        good_write(8'hC2, 8'h00, 24'h0D_0E_0F, 16'h0001, 32'h01020304);
        idle(6);
        check_reg(1'b0, 1, 32'h01020304, "R9");
        check_quiet("R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule